// File: doc/BRIEF.md
# PHY Management Register Bridge

This block lets a host reach the management registers of an external PHY through one 32-bit access register. The host starts an access by writing that register. The block then clocks a complete management frame out on the MDC/MDIO pins. It captures read data from the PHY and writes the outcome back into the same register. The host learns that the access is over by polling one flag bit.

The flag bit is set differently for the two directions. A host write with the flag low requests a read, and the bridge raises the flag once the read data is in place. A host write with the flag high requests a write, and the bridge drops the flag once the frame has gone out. Every frame is addressed to PHY address 1. MDC comes from dividing the system clock, and its half-period in system cycles is a parameter.

Top module: `mdio_access_bridge`

## Requirements
- R1: The access register holds data in bits 15:0, the PHY register number in bits 20:16 and the flag in bit 31. Bits 30:21 always read as 0, whatever the host wrote there.
- R2: A host write with bit 31 = 0 starts a read of the addressed PHY register. On completion, bit 31 reads 1 and bits 15:0 hold the data returned by the PHY.
- R3: A host write with bit 31 = 1 starts a write of bits 15:0 to the addressed PHY register. On completion, bit 31 reads 0 and the PHY holds that value.
- R4: Each frame is 32 ones, then start bits 0,1, then opcode 1,0 for a read or 0,1 for a write. The PHY address follows as 5 bits of value 1, then the register number as 5 bits, two turnaround bits, and 16 data bits. All fields are sent MSB first.
- R5: During a read, the bridge stops driving MDIO from the second turnaround bit to the end of the frame. It samples the data bits on the rising edge of MDC.
- R6: MDC stays low for HALF_DIV system clocks and high for HALF_DIV system clocks (10 + 10 at 50 MHz, i.e. 2.5 MHz). MDC is low when idle. MDIO and its enable change only while MDC is low, on its falling edge.
- R7: A host write while a frame is in progress is ignored. It starts no frame and changes no register field.
- R8: While a frame is in progress, the register reads back with the flag and the register number exactly as the host wrote them.
- R9: After reset, the register reads 0, MDC is low and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the access register |
| wr_data | input | 32 | Host write value |
| rd_data | output | 32 | Current access register contents |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven by the bridge |
| mdio_oe | output | 1 | High while the bridge drives MDIO |
| mdio_i | input | 1 | Management data seen on the pin |

## Verification
The embedded assertions check the following on every cycle:
- MDIO and its enable hold still while MDC is high.
- MDC is low whenever the bridge is idle.
- The flag and the register number do not move during a frame.
- MDIO is released in the read-data window and driven through the whole of a write frame.

The bench's PHY model and scoreboard show the rest. It decodes the preamble, opcode and addresses, returns chosen bit patterns MSB first, stores written values, and checks that an access issued mid-frame leaves no trace. A stopwatch check measures the length of each MDC phase.

// File: rtl/mdio_access_bridge.sv
module mdio_access_bridge #(
  parameter int HALF_DIV = 10,
  parameter int PRE_LEN = 32,
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME = PRE_LEN + 32;
  localparam int DW = $clog2(HALF_DIV + 1);
  localparam int BW = $clog2(FRAME + 1);
  localparam int DATA_START = FRAME - 16;
  localparam int TA2 = FRAME - 17;

  logic [31:0]      reg_q;
  logic             busy_q, mdc_q, oe_q;
  logic [DW-1:0]    div_q;
  logic [BW-1:0]    bit_q;
  logic [FRAME-1:0] sh_q;
  logic [15:0]      cap_q;
  logic             unused_bits;

  wire is_rd = ~reg_q[31];
  wire tick  = busy_q && (div_q == DW'(HALF_DIV - 1));
  wire rise  = tick && !mdc_q;
  wire fall  = tick && mdc_q;
  wire last  = fall && (bit_q == BW'(FRAME - 1));
  wire [BW-1:0] nxt_bit = bit_q + BW'(1);

  assign unused_bits = ^wr_data[30:21];
  assign rd_data = reg_q;
  assign mdc     = mdc_q;
  assign mdio_oe = oe_q;
  assign mdio_o  = sh_q[FRAME-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      busy_q <= 1'b0;
      mdc_q  <= 1'b0;
      oe_q   <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      cap_q  <= '0;
    end else if (!busy_q) begin
      if (wr_en) begin
        reg_q  <= {wr_data[31], 10'd0, wr_data[20:0]};
        busy_q <= 1'b1;
        div_q  <= '0;
        bit_q  <= '0;
        mdc_q  <= 1'b0;
        oe_q   <= 1'b1;
        sh_q   <= {{PRE_LEN{1'b1}}, 2'b01,
                   wr_data[31] ? 2'b01 : 2'b10,
                   PHY_ADDR, wr_data[20:16],
                   wr_data[31] ? 2'b10 : 2'b11,
                   wr_data[31] ? wr_data[15:0] : 16'h0000};
      end
    end else begin
      div_q <= tick ? '0 : div_q + DW'(1);
      if (tick) mdc_q <= ~mdc_q;
      if (rise && is_rd && bit_q >= BW'(DATA_START))
        cap_q <= {cap_q[14:0], mdio_i};
      if (last) begin
        busy_q    <= 1'b0;
        oe_q      <= 1'b0;
        reg_q[31] <= is_rd;
        if (is_rd) reg_q[15:0] <= cap_q;
      end else if (fall) begin
        bit_q <= nxt_bit;
        sh_q  <= {sh_q[FRAME-2:0], 1'b0};
        oe_q  <= !(is_rd && nxt_bit >= BW'(TA2));
      end
    end
  end

  // R6
  mdio_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_q && $past(mdc_q)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  // R6
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc_q);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(reg_q[31]) && $stable(reg_q[20:16])));
  // R7
  ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q) && $past(wr_en)) |-> $stable(reg_q[20:16]));
  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && is_rd && bit_q >= BW'(TA2)) |-> !mdio_oe);
  // R4
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !is_rd) |-> mdio_oe);
endmodule

// File: tb/tb_mdio_access_bridge.sv
module tb_mdio_access_bridge;
  localparam int HALF = 10;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, mdio_i;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic mdc, mdio_o, mdio_oe;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mdio_access_bridge dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // PHY model
  logic [15:0] phy_mem [32];
  int ones = 0, k = 0, frame_cnt = 0, last_pre = 0, rel_err = 0, fmt_err = 0;
  bit in_frame = 0;
  logic [11:0] hdr = '0;
  logic [15:0] wsh = '0;
  logic [1:0] last_op = '0;
  logic [4:0] last_phy = '0, last_reg = '0;

  always @(posedge mdc) begin
    logic b;
    b = mdio_oe ? mdio_o : 1'b1;
    if (!in_frame) begin
      if (b) ones++;
      else begin
        if (ones >= 32) begin in_frame = 1; k = -1; last_pre = ones; end
        ones = 0;
      end
    end else begin
      if (k < 0) begin if (!b) fmt_err++; end
      else if (k < 12) hdr = {hdr[10:0], b};
      else if (k < 14) begin if (k == 13 && hdr[11:10] == 2'b10 && mdio_oe) rel_err++; end
      else begin
        if (hdr[11:10] == 2'b10 && mdio_oe) rel_err++;
        wsh = {wsh[14:0], b};
      end
      if (k == 29) begin
        in_frame = 0;
        frame_cnt++;
        last_op = hdr[11:10]; last_phy = hdr[9:5]; last_reg = hdr[4:0];
        if (hdr[11:10] == 2'b01) phy_mem[hdr[4:0]] = wsh;
      end
      k++;
    end
  end

  always @* begin
    if (in_frame && k >= 13 && hdr[11:10] == 2'b10)
      mdio_i = (k == 13) ? 1'b0 : phy_mem[hdr[4:0]][29-k];
    else
      mdio_i = 1'b1;
  end

  // scoreboard
  logic [31:0] exp_q[$];
  string tag_q[$];
  int done_cnt = 0;
  logic wr_seen = 1'b0, prev_flag = 1'b0;
  always @(posedge clk) wr_seen <= wr_en;
  always @(negedge clk) begin
    if (rst_n && rd_data[31] !== prev_flag && !wr_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2/R3 unexpected completion actual=%h expected=none", rd_data);
      end else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      done_cnt++;
    end
    prev_flag = rd_data[31];
  end

  task automatic issue(logic [31:0] w, logic [31:0] exp, string tag, bit push);
    @(negedge clk);
    if (push) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    wr_data = w; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done(int target);
    int t = 0;
    while (done_cnt < target && t < 5000) begin @(negedge clk); t++; end
    if (done_cnt < target) begin
      checks++; errors++;
      $display("FAIL R2/R3 completion timeout actual=%0d expected=%0d", done_cnt, target);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    int n;
    realtime t1, t2, t3;
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'(i * 16'h0731 + 16'h1000);
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check("R9 reg", rd_data, 32'h0);
    check("R9 mdc", {31'd0, mdc}, 32'd0);
    check("R9 oe", {31'd0, mdio_oe}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R3 write, R4 frame fields, R8 flag held
    n = done_cnt;
    issue(32'h8005_A5C3, 32'h8005_A5C3 & 32'h001F_FFFF, "R3 write completion", 1);
    repeat (300) @(negedge clk);
    check("R8 flag held during write", {31'd0, rd_data[31]}, 32'd1);
    // R6 MDC phase lengths
    @(posedge mdc); t1 = $realtime;
    @(negedge mdc); t2 = $realtime;
    @(posedge mdc); t3 = $realtime;
    check("R6 mdc high", 32'(int'((t2 - t1) / 20.0)), HALF);
    check("R6 mdc low", 32'(int'((t3 - t2) / 20.0)), HALF);
    wait_done(n + 1);
    check("R3 phy stored", {16'd0, phy_mem[5]}, 32'h0000_A5C3);
    check("R4 opcode write", {30'd0, last_op}, 32'd1);
    check("R4 phy addr", {27'd0, last_phy}, 32'd1);
    check("R4 reg addr", {27'd0, last_reg}, 32'd5);
    check("R4 preamble", last_pre, 32);

    // R2 read back
    issue(32'h0005_0000, 32'h8005_A5C3, "R2 read completion", 1);
    wait_done(n + 2);
    check("R4 opcode read", {30'd0, last_op}, 32'd2);

    // R1 ignored bits, R2 read with data pattern from PHY
    phy_mem[31] = 16'h8001;
    issue(32'h7FFF_1234, 32'h801F_8001, "R1/R2 read addr31 msb-first", 1);
    wait_done(n + 3);
    check("R1 bits 30:21 zero", {22'd0, rd_data[30:21]}, 32'd0);

    // R7 write during busy ignored, R8 fields held during read
    phy_mem[7] = 16'h3C5A;
    issue(32'h0007_0000, 32'h8007_3C5A, "R7 read unaffected", 1);
    repeat (200) @(negedge clk);
    check("R8 flag held during read", {31'd0, rd_data[31]}, 32'd0);
    check("R8 reg addr held", {27'd0, rd_data[20:16]}, 32'd7);
    issue(32'h8009_DEAD, 32'h0, "", 0);
    @(negedge clk);
    check("R7 reg addr unchanged", {27'd0, rd_data[20:16]}, 32'd7);
    wait_done(n + 4);
    repeat (2000) @(negedge clk);
    check("R7 single frame", frame_cnt, n + 4);
    check("R7 phy reg 9 untouched", {16'd0, phy_mem[9]}, {16'd0, 16'(9 * 16'h0731 + 16'h1000)});

    // boundary values
    issue(32'h8000_0000, 32'h0000_0000, "R3 write zero addr0", 1);
    wait_done(n + 5);
    check("R3 phy reg0 zero", {16'd0, phy_mem[0]}, 32'd0);
    issue(32'h801F_FFFF, 32'h001F_FFFF, "R3 write ones addr31", 1);
    wait_done(n + 6);
    issue(32'h001F_0000, 32'h801F_FFFF, "R2 read ones addr31", 1);
    wait_done(n + 7);
    issue(32'h0000_FFFF, 32'h8000_0000, "R2 read zero addr0", 1);
    wait_done(n + 8);

    // R5 bus release and framing
    check("R5 released in read window", rel_err, 0);
    check("R4 start bits", fmt_err, 0);
    check("R2/R3 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule